// File: doc/BRIEF.md
# Save-Restorable Integer Divide Unit

This block is a 32-bit integer divide unit on a simple single-cycle register bus. Software writes a dividend and a divisor through either a signed or an unsigned pair of register addresses. Each operand write starts a new division using the signedness of the address just written. The quotient and remainder become readable a fixed eight clock cycles later. A status register shows two things: whether the result is ready, and whether the unit holds state that nobody has consumed yet.

The unit's full state is exposed so that an interrupt handler can borrow it. The handler looks at the "unconsumed" flag. If the flag is set, the handler reads out both operands and both results, runs its own divisions, and then writes everything back. Writing a result register cancels any division in flight, so the restored values cannot be overwritten. The write also marks the result as ready and unconsumed. The signedness of the last division is not stored anywhere software can see, so a handler must wait out the full latency before saving.

Top module: `divsave_top`

## Requirements
- R1: Register byte offsets: 0x60 unsigned dividend, 0x64 unsigned divisor, 0x68 signed dividend, 0x6C signed divisor, 0x70 quotient, 0x74 remainder, 0x78 status. The signed and unsigned operand addresses share one dividend store and one divisor store, and each reads back the last value written. Any other offset reads as zero and ignores writes.
- R2: The status register holds ready in bit 0 and unconsumed in bit 1, with all other bits zero. Writes to it have no effect. After reset it reads 0x1.
- R3: After an operand write, ready reads 0 until seven more clock edges have passed. It reads 1 from the eighth edge after the write onward. A further operand write during that window restarts the count.
- R4: Every operand write sets the unconsumed flag and starts a division on the current dividend and divisor. The division is signed when the address written was 0x68 or 0x6C, and unsigned otherwise.
- R5: An unsigned division yields quotient = floor(n/d) and remainder = n mod d.
- R6: A signed division truncates the quotient toward zero, and the remainder takes the sign of the dividend. The most negative dividend divided by -1 gives quotient 0x80000000 and remainder 0.
- R7: Dividing by zero yields remainder = dividend and a quotient of all ones. The one exception is a signed division with a negative dividend, which gives a quotient of +1.
- R8: Reading the quotient clears the unconsumed flag. Reading the remainder leaves it unchanged.
- R9: Writing the quotient or the remainder register stores the written value and cancels any division in progress. A register that was not written keeps its previous value. Both ready and unconsumed read 1 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |

## Verification
The checker watches the flags on every cycle: ready drops after any operand write and rises exactly eight edges later unless a result write raised it earlier. It also checks that the unconsumed flag follows operand writes, quotient reads, remainder reads, result writes and status writes as required. Numeric correctness can only be shown by the bench scenarios: unsigned and signed quotients and remainders, division by zero, and overflow. The same holds for signedness taken from the address written, and for a restored value surviving a cancelled division.

// File: rtl/divsave_pkg.sv
// Package: register offsets, status bit positions and the address decode
// shared by the divide unit and its checker.
// Assumes byte addressing with word-aligned registers inside an 8-bit window.
package divsave_pkg;
    localparam int ADDR_W = 8;

    localparam logic [ADDR_W-1:0] OFF_UDVD = 8'h60;
    localparam logic [ADDR_W-1:0] OFF_UDSR = 8'h64;
    localparam logic [ADDR_W-1:0] OFF_SDVD = 8'h68;
    localparam logic [ADDR_W-1:0] OFF_SDSR = 8'h6C;
    localparam logic [ADDR_W-1:0] OFF_QUO  = 8'h70;
    localparam logic [ADDR_W-1:0] OFF_REM  = 8'h74;
    localparam logic [ADDR_W-1:0] OFF_STAT = 8'h78;

    localparam int STAT_READY_BIT = 0;
    localparam int STAT_DIRTY_BIT = 1;

    typedef enum logic [2:0] {
        SEL_NONE, SEL_UDVD, SEL_UDSR, SEL_SDVD, SEL_SDSR, SEL_QUO, SEL_REM, SEL_STAT
    } reg_sel_e;

    // Map a byte offset onto the register it selects.
    function automatic reg_sel_e decode(input logic [ADDR_W-1:0] a);
        case (a)
            OFF_UDVD: return SEL_UDVD;
            OFF_UDSR: return SEL_UDSR;
            OFF_SDVD: return SEL_SDVD;
            OFF_SDSR: return SEL_SDSR;
            OFF_QUO:  return SEL_QUO;
            OFF_REM:  return SEL_REM;
            OFF_STAT: return SEL_STAT;
            default:  return SEL_NONE;
        endcase
    endfunction
endpackage

// File: rtl/divsave_sign.sv
// Module: divsave_sign
// Converts a dividend/divisor pair into magnitudes, and works out whether the
// quotient and remainder must be negated after an unsigned divide.
// Assumes two's complement operands; pure combinational logic.
module divsave_sign #(
    parameter int W = 32
) (
    input  logic [W-1:0] num,
    input  logic [W-1:0] den,
    input  logic         is_signed,
    output logic [W-1:0] mag_num,
    output logic [W-1:0] mag_den,
    output logic         neg_quo,
    output logic         neg_rem
);
    logic num_neg, den_neg;

    // Take magnitudes and derive the result sign flags.
    always_comb begin
        num_neg = is_signed & num[W-1];
        den_neg = is_signed & den[W-1];
        mag_num = num_neg ? (~num + 1'b1) : num;
        mag_den = den_neg ? (~den + 1'b1) : den;
        neg_quo = num_neg ^ den_neg;
        neg_rem = num_neg;
    end
endmodule

// File: rtl/divsave_engine.sv
// Module: divsave_engine
// Iterative restoring divider that retires STEP quotient bits per cycle, so
// one division takes W/STEP cycles. It applies the sign fix-up to the last
// iteration's output and pulses done in the cycle whose edge finishes the work.
// Assumes start and abort are never high together; start wins if they are.
module divsave_engine #(
    parameter int W    = 32,
    parameter int STEP = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         abort,
    input  logic [W-1:0] mag_num,
    input  logic [W-1:0] mag_den,
    input  logic         neg_quo,
    input  logic         neg_rem,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] res_quo,
    output logic [W-1:0] res_rem
);
    localparam int LAT = W / STEP;
    localparam int CW  = $clog2(LAT + 1);

    logic [W-1:0]  rem_q, quo_q, den_q;
    logic [CW-1:0] cnt_q;
    logic          busy_q, nq_q, nr_q;
    logic [W:0]    r_t;
    logic [W-1:0]  q_t;

    // One iteration step: STEP shift-compare-subtract stages.
    always_comb begin
        r_t = {1'b0, rem_q};
        q_t = quo_q;
        for (int i = 0; i < STEP; i++) begin
            r_t = {r_t[W-1:0], q_t[W-1]};
            q_t = {q_t[W-2:0], 1'b0};
            if (r_t >= {1'b0, den_q}) begin
                r_t    = r_t - {1'b0, den_q};
                q_t[0] = 1'b1;
            end
        end
    end

    // Sign fix-up on the values produced by the final step.
    always_comb begin
        res_quo = nq_q ? (~q_t + 1'b1) : q_t;
        res_rem = nr_q ? (~r_t[W-1:0] + 1'b1) : r_t[W-1:0];
    end

    assign busy = busy_q;
    assign done = busy_q && (cnt_q == CW'(1));

    // Load on start, stop on abort, otherwise advance one step while busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            rem_q  <= '0;
            quo_q  <= '0;
            den_q  <= '0;
            nq_q   <= 1'b0;
            nr_q   <= 1'b0;
        end else if (start) begin
            busy_q <= 1'b1;
            cnt_q  <= CW'(LAT);
            rem_q  <= '0;
            quo_q  <= mag_num;
            den_q  <= mag_den;
            nq_q   <= neg_quo;
            nr_q   <= neg_rem;
        end else if (abort) begin
            busy_q <= 1'b0;
        end else if (busy_q) begin
            rem_q <= r_t[W-1:0];
            quo_q <= q_t;
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CW'(1)) busy_q <= 1'b0;
        end
    end
endmodule

// File: rtl/divsave_top.sv
// Module: divsave_top
// Bus-facing divide unit: operand and result registers, the ready and
// unconsumed flags, and the read mux. Each operand write restarts the engine
// with the signedness of the address used; result writes cancel it.
// Assumes at most one bus access per cycle; read data is combinational.
module divsave_top
    import divsave_pkg::*;
#(
    parameter int W    = 32,
    parameter int STEP = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata
);
    reg_sel_e     sel;
    logic         wr_dvd, wr_dsr, wr_sgn, op_wr, wr_quo, wr_rem, res_wr, rd_quo;
    logic [W-1:0] dvd_q, dsr_q, quo_q, rem_q, nxt_dvd, nxt_dsr;
    logic [W-1:0] mag_num, mag_den, eng_quo, eng_rem;
    logic         neg_quo, neg_rem, eng_busy, eng_done;
    logic         ready_q, dirty_q;

    // Decode the access into per-register strobes.
    always_comb begin
        sel     = decode(bus_addr);
        wr_dvd  = bus_sel && bus_we && (sel == SEL_UDVD || sel == SEL_SDVD);
        wr_dsr  = bus_sel && bus_we && (sel == SEL_UDSR || sel == SEL_SDSR);
        wr_sgn  = bus_sel && bus_we && (sel == SEL_SDVD || sel == SEL_SDSR);
        op_wr   = wr_dvd || wr_dsr;
        wr_quo  = bus_sel && bus_we && (sel == SEL_QUO);
        wr_rem  = bus_sel && bus_we && (sel == SEL_REM);
        res_wr  = wr_quo || wr_rem;
        rd_quo  = bus_sel && !bus_we && (sel == SEL_QUO);
        nxt_dvd = wr_dvd ? bus_wdata : dvd_q;
        nxt_dsr = wr_dsr ? bus_wdata : dsr_q;
    end

    divsave_sign #(.W(W)) u_sign (
        .num       (nxt_dvd),
        .den       (nxt_dsr),
        .is_signed (wr_sgn),
        .mag_num   (mag_num),
        .mag_den   (mag_den),
        .neg_quo   (neg_quo),
        .neg_rem   (neg_rem)
    );

    divsave_engine #(.W(W), .STEP(STEP)) u_eng (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (op_wr),
        .abort   (res_wr),
        .mag_num (mag_num),
        .mag_den (mag_den),
        .neg_quo (neg_quo),
        .neg_rem (neg_rem),
        .busy    (eng_busy),
        .done    (eng_done),
        .res_quo (eng_quo),
        .res_rem (eng_rem)
    );

    // Operand and result storage; a bus write beats an engine completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dvd_q <= '0;
            dsr_q <= '0;
            quo_q <= '0;
            rem_q <= '0;
        end else begin
            dvd_q <= nxt_dvd;
            dsr_q <= nxt_dsr;
            if (wr_quo)                  quo_q <= bus_wdata;
            else if (eng_done && !res_wr) quo_q <= eng_quo;
            if (wr_rem)                  rem_q <= bus_wdata;
            else if (eng_done && !res_wr) rem_q <= eng_rem;
        end
    end

    // Ready flag: low while a division runs, high on completion or restore.
    always_ff @(posedge clk) begin
        if (!rst_n)                 ready_q <= 1'b1;
        else if (op_wr)             ready_q <= 1'b0;
        else if (res_wr || eng_done) ready_q <= 1'b1;
    end

    // Unconsumed flag: set by any state write, cleared by a quotient read.
    always_ff @(posedge clk) begin
        if (!rst_n)                dirty_q <= 1'b0;
        else if (op_wr || res_wr)  dirty_q <= 1'b1;
        else if (rd_quo)           dirty_q <= 1'b0;
    end

    // Read data selection.
    always_comb begin
        bus_rdata = '0;
        case (sel)
            SEL_UDVD, SEL_SDVD: bus_rdata = dvd_q;
            SEL_UDSR, SEL_SDSR: bus_rdata = dsr_q;
            SEL_QUO:            bus_rdata = quo_q;
            SEL_REM:            bus_rdata = rem_q;
            SEL_STAT: begin
                bus_rdata[STAT_READY_BIT] = ready_q;
                bus_rdata[STAT_DIRTY_BIT] = dirty_q;
            end
            default:            bus_rdata = '0;
        endcase
    end

    logic unused_busy;
    assign unused_busy = eng_busy;
endmodule

// File: rtl/divsave_chk.sv
// Module: divsave_chk
// Checker bound into divsave_top: watches bus accesses and the two flags,
// and times the ready flag against a cycle counter started by operand writes.
// Assumes LAT matches the engine's W/STEP and stays below 255.
module divsave_chk
    import divsave_pkg::*;
#(
    parameter int LAT = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              ready,
    input logic              dirty
);
    reg_sel_e   sel;
    logic       op_wr, res_wr, rd_quo, rd_rem, stat_wr;
    logic [7:0] lat_cnt;

    // Classify the current access.
    always_comb begin
        sel     = decode(bus_addr);
        op_wr   = bus_sel && bus_we && (sel == SEL_UDVD || sel == SEL_UDSR ||
                                        sel == SEL_SDVD || sel == SEL_SDSR);
        res_wr  = bus_sel && bus_we && (sel == SEL_QUO || sel == SEL_REM);
        stat_wr = bus_sel && bus_we && (sel == SEL_STAT);
        rd_quo  = bus_sel && !bus_we && (sel == SEL_QUO);
        rd_rem  = bus_sel && !bus_we && (sel == SEL_REM);
    end

    // Cycles since the most recent operand write, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)               lat_cnt <= 8'hFF;
        else if (op_wr)           lat_cnt <= 8'h00;
        else if (lat_cnt != 8'hFF) lat_cnt <= lat_cnt + 1'b1;
    end

    a_r3_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
        op_wr |=> !ready);

    a_r3_ready_latency: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ready) && !$past(res_wr)) |-> (lat_cnt == 8'(LAT)));

    a_r4_dirty_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        op_wr |=> dirty);

    a_r8_quo_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        rd_quo |=> !dirty);

    a_r8_rem_read_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        rd_rem |=> (dirty == $past(dirty)));

    a_r9_restore_flags: assert property (@(posedge clk) disable iff (!rst_n)
        res_wr |=> (ready && dirty));

    a_r2_stat_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
        stat_wr |=> (dirty == $past(dirty)));
endmodule

bind divsave_top divsave_chk #(.LAT(W / STEP)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_sel  (bus_sel),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .ready    (ready_q),
    .dirty    (dirty_q)
);

// File: tb/divsave_top_tb_top.sv
`timescale 1ns/1ps
module divsave_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    int          n_chk = 0;
    int          n_bad = 0;

    always #2.5 clk = ~clk;

    divsave_top dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    // Called at a falling edge; the access happens at the next rising edge.
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    // Expected {remainder, quotient} from the arithmetic rules.
    function automatic logic [63:0] ref_div(input bit sgn, input logic [31:0] n, input logic [31:0] d);
        logic [31:0] q, r, mn, md;
        if (d == 0) begin
            q = (sgn && n[31]) ? 32'd1 : 32'hFFFF_FFFF;
            r = n;
        end else if (!sgn) begin
            q = n / d; r = n % d;
        end else begin
            mn = n[31] ? (~n + 1) : n;
            md = d[31] ? (~d + 1) : d;
            q = mn / md; r = mn % md;
            if (n[31] ^ d[31]) q = ~q + 1;
            if (n[31]) r = ~r + 1;
        end
        return {r, q};
    endfunction

    task automatic run_div(input string req, input bit sgn, input logic [31:0] n, input logic [31:0] d);
        logic [31:0] got_r, got_q, st;
        logic [63:0] e;
        e = ref_div(sgn, n, d);
        wr(sgn ? 8'h68 : 8'h60, n);
        wr(sgn ? 8'h6C : 8'h64, d);
        repeat (8) @(negedge clk);
        rd(8'h74, got_r);
        rd(8'h70, got_q);
        check({req, " remainder"}, got_r, e[63:32]);
        check({req, " quotient"}, got_q, e[31:0]);
        rd(8'h78, st);
        check("R8 flag cleared by quotient read", st, 32'h1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog got timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v, n, d;
        int unsigned seed;
        seed = $urandom(32'd2718);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        rd(8'h78, v); check("R2 status after reset", v, 32'h1);
        rd(8'h70, v); check("R2 quotient after reset", v, 32'h0);

        // R1: aliasing and readback
        wr(8'h68, 32'hDEAD_BEEF);
        rd(8'h60, v); check("R1 dividend alias", v, 32'hDEAD_BEEF);
        wr(8'h64, 32'h0000_1234);
        rd(8'h6C, v); check("R1 divisor alias", v, 32'h0000_1234);
        wr(8'h7C, 32'hFFFF_FFFF);
        rd(8'h7C, v); check("R1 unmapped reads zero", v, 32'h0);
        repeat (10) @(negedge clk);

        // R3: latency window and restart
        wr(8'h60, 32'd200);
        repeat (3) @(negedge clk);
        wr(8'h64, 32'd10);
        repeat (7) @(negedge clk);
        rd(8'h78, v); check("R3 not ready 7 edges after write", v[0], 1'b0);
        rd(8'h78, v); check("R3 ready 8 edges after write", v, 32'h3);
        rd(8'h74, v); check("R8 remainder read keeps flag", v, 32'd0);
        rd(8'h78, v); check("R8 flag kept after remainder read", v, 32'h3);
        rd(8'h70, v); check("R5 restarted quotient", v, 32'd20);

        // R2: status write ignored
        wr(8'h78, 32'h0);
        rd(8'h78, v); check("R2 status write ignored", v, 32'h1);

        // R4: signedness from the address last written
        wr(8'h68, 32'hFFFF_FFEC);
        wr(8'h64, 32'd3);
        rd(8'h78, v); check("R4 flag set by operand write", v[1], 1'b1);
        repeat (7) @(negedge clk);
        rd(8'h70, v); check("R4 unsigned via last address", v, ref_div(1'b0, 32'hFFFF_FFEC, 32'd3));

        run_div("R5", 1'b0, 32'd100, 32'd7);
        run_div("R6", 1'b1, -32'sd100, 32'd7);
        run_div("R6", 1'b1, 32'd100, -32'sd7);
        run_div("R6", 1'b1, -32'sd100, -32'sd7);
        run_div("R6 overflow", 1'b1, 32'h8000_0000, 32'hFFFF_FFFF);
        run_div("R7 unsigned", 1'b0, 32'd12345, 32'd0);
        run_div("R7 signed negative", 1'b1, -32'sd55, 32'd0);
        run_div("R7 signed positive", 1'b1, 32'd55, 32'd0);
        run_div("R5 max", 1'b0, 32'hFFFF_FFFF, 32'd1);

        // R9: restore mid-calculation
        wr(8'h60, 32'd1000);
        wr(8'h64, 32'd3);
        repeat (2) @(negedge clk);
        wr(8'h74, 32'h0000_AAAA);
        wr(8'h70, 32'h0000_5555);
        rd(8'h78, v); check("R9 flags after restore", v, 32'h3);
        repeat (10) @(negedge clk);
        rd(8'h74, v); check("R9 restored remainder", v, 32'h0000_AAAA);
        rd(8'h70, v); check("R9 restored quotient", v, 32'h0000_5555);

        // R9: remainder write alone cancels the division
        wr(8'h60, 32'd50);
        wr(8'h64, 32'd5);
        repeat (2) @(negedge clk);
        wr(8'h74, 32'h77);
        rd(8'h78, v); check("R9 flags after remainder write", v, 32'h3);
        repeat (10) @(negedge clk);
        rd(8'h70, v); check("R9 quotient untouched by cancelled division", v, 32'h0000_5555);
        rd(8'h74, v); check("R9 remainder kept", v, 32'h77);

        // Random mix
        for (int i = 0; i < 300; i++) begin
            n = $urandom;
            case ($urandom % 4)
                0: d = $urandom;
                1: d = $urandom % 256;
                2: d = $urandom % 65536;
                default: d = ($urandom % 8 == 0) ? 32'd0 : -($urandom % 1000);
            endcase
            run_div((i % 2) ? "R6 random" : "R5 random", bit'(i % 2), n, d);
        end

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule